// File: doc/BRIEF.md
# Two-Point Calibration Constant Sequencer

This block works out the gain and offset correction constants for one analog-to-digital converter. It needs two conversions of fixed internal reference levels to do so. On a start pulse it asks for an uncorrected conversion of the channel that carries a quarter of the reference span. It then asks for the channel that carries three quarters of the span. Each request waits on a ready/valid handshake, and each raw result comes back on a response strobe.

With the two raw points captured, the block divides the span of the ideal results by the span of the raw results. A sequential restoring divider does the division, and the quotient is a Q1.14 gain. The offset is then solved from the upper point. The block issues two writes, tagged with the converter chosen at start: the gain first, then the offset. A one-cycle done pulse closes the sequence. If the raw points are not strictly increasing, the sequence aborts without writing and raises an error flag with the done pulse.

The ideal results are 1024 at the quarter point and 3072 at the three-quarter point, for a 12-bit result range. These values, the channel numbers and all widths are parameters.

Top module: `cal_const_seq`

## Requirements
- R1: After reset, req_valid_o, wr_valid_o, done_o and err_o are all low, and they stay low until start_i is seen.
- R2: A start_i seen while idle latches conv_sel_i and raises req_valid_o with req_chan_o = 44, req_cal_o = 0 and req_conv_o equal to the latched converter. The request holds with the same channel until req_ready_i is high on a clock edge. The next rsp_valid_i then captures rsp_data_i as the low raw point.
- R3: Once the low raw point is captured, a second request follows for channel 43 with req_cal_o = 0. The next response is captured as the high raw point. The channel order is always 44 then 43.
- R4: The gain equals floor(2048 * 16384 / (high raw − low raw)) as an unsigned 15-bit Q1.14 value. Any quotient above 32767 is written as 32767.
- R5: The offset equals 3070 − floor(gain * high raw / 16384). It is written as a 16-bit two's-complement value.
- R6: If the high raw point is less than or equal to the low raw point, no write is issued, and done_o pulses with err_o = 1.
- R7: On success, wr_valid_o is high for exactly two consecutive cycles. The first write carries wr_kind_o = 0 (gain) and the second carries wr_kind_o = 1 (offset), both with wr_conv_o equal to the converter latched at start. done_o is high in the cycle after the offset write, and err_o is 0.
- R8: done_o is high for exactly one cycle per sequence. err_o is never high without done_o.
- R9: A start_i that arrives while a sequence is in progress is ignored. It does not change the converter tag, and it does not cause a further sequence after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration sequence (taken only when idle) |
| conv_sel_i | input | SEL_W | Converter to calibrate, latched at start |
| req_valid_o | output | 1 | Conversion request valid |
| req_ready_i | input | 1 | Conversion request accepted |
| req_chan_o | output | CHAN_W | Reference channel to convert |
| req_conv_o | output | SEL_W | Converter the request is for |
| req_cal_o | output | 1 | Correction enable for the conversion (always 0) |
| rsp_valid_i | input | 1 | Raw result strobe |
| rsp_data_i | input | RAW_W | Raw conversion result |
| wr_valid_o | output | 1 | Constant register write strobe |
| wr_kind_o | output | 1 | 0 = gain register, 1 = offset register |
| wr_conv_o | output | SEL_W | Converter whose register is written |
| wr_data_o | output | OFFS_W | Constant value (gain zero-extended, offset two's complement) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Abort flag, valid with done_o |

## Verification
The hardest case to reach from the ports is a start request that arrives while the sequencer is parked waiting for a response. In that case it must not retag or restart. The bench pulses start_i with the other converter number after the low request has been accepted and before its result is returned. It then checks the request and write tags and watches for ten idle cycles after done. The divider edges are also hard to hit. The bench drives raw spans of exactly 1024 and 1025, which sit on either side of the gain saturation point, and equal and reversed raw points, which drive the abort path.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_REQ_LOW,
      ST_WAIT_LOW,
      ST_REQ_HIGH,
      ST_WAIT_HIGH,
      ST_DIVIDE,
      ST_COMPUTE_OFFSET,
      ST_WRITE_GAIN,
      ST_WRITE_OFFSET,
      ST_DONE
   } cal_state_e;

   localparam logic WR_KIND_GAIN   = 1'b0;
   localparam logic WR_KIND_OFFSET = 1'b1;

endpackage

// File: rtl/cal_restoring_div.sv
module cal_restoring_div #(
   parameter int DVD_W = 26,
   parameter int DVS_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [DVD_W-1:0] dividend_i,
   input  logic [DVS_W-1:0] divisor_i,
   output logic             done_o,
   output logic [DVD_W-1:0] quot_o
);

   localparam int CNT_W = $clog2(DVD_W + 1);

   if (DVD_W < 2) begin : g_bad_dvd
      $error("cal_restoring_div: DVD_W must be at least 2");
   end
   if (DVS_W < 1) begin : g_bad_dvs
      $error("cal_restoring_div: DVS_W must be at least 1");
   end

   logic [DVD_W-1:0] dvd_q;
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] rem_q;
   logic [DVS_W-1:0] dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   logic [DVS_W:0]   trial;
   logic [DVS_W:0]   diff;
   logic             fits;

   assign trial = {rem_q, dvd_q[DVD_W-1]};
   assign fits  = trial >= {1'b0, dvs_q};
   assign diff  = trial - {1'b0, dvs_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dvd_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            dvd_q  <= dividend_i;
            dvs_q  <= divisor_i;
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= CNT_W'(DVD_W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            quo_q <= {quo_q[DVD_W-2:0], fits};
            dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quot_o = quo_q;

   // R4: a finished division leaves a remainder below the divisor
   a_r4_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (rem_q < dvs_q));

   // R4: the divider reports completion for one cycle only
   a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);

endmodule

// File: rtl/cal_offset_calc.sv
module cal_offset_calc #(
   parameter int GAIN_W    = 15,
   parameter int RAW_W     = 12,
   parameter int FRAC_W    = 14,
   parameter int OFFS_W    = 16,
   parameter int EXP_HIGH  = 3072,
   parameter int OFFS_BIAS = 2,
   parameter bit ROUND     = 1'b0
) (
   input  logic [GAIN_W-1:0]        gain_i,
   input  logic [RAW_W-1:0]         raw_i,
   output logic signed [OFFS_W-1:0] offs_o
);

   localparam int PROD_W = GAIN_W + RAW_W;
   localparam int SCL_W  = PROD_W - FRAC_W + 1;
   localparam logic signed [OFFS_W-1:0] BASE = OFFS_W'(EXP_HIGH - OFFS_BIAS);

   if (FRAC_W < 1 || FRAC_W >= PROD_W) begin : g_bad_frac
      $error("cal_offset_calc: FRAC_W out of range");
   end
   if (OFFS_W < SCL_W + 1) begin : g_bad_offs
      $error("cal_offset_calc: OFFS_W too narrow for the scaled product");
   end

   logic [PROD_W-1:0] prod;
   logic [SCL_W-1:0]  scaled;

   assign prod = PROD_W'(gain_i) * PROD_W'(raw_i);

   if (ROUND) begin : g_round
      logic [PROD_W:0] biased;
      assign biased = {1'b0, prod} + (PROD_W+1)'(2 ** (FRAC_W - 1));
      assign scaled = biased[PROD_W:FRAC_W];
   end else begin : g_trunc
      assign scaled = {1'b0, prod[PROD_W-1:FRAC_W]};
   end

   assign offs_o = BASE - $signed(OFFS_W'(scaled));

endmodule

// File: rtl/cal_const_seq.sv
module cal_const_seq
   import cal_seq_pkg::*;
#(
   parameter int NUM_CONV  = 2,
   parameter int CHAN_W    = 6,
   parameter int CHAN_LOW  = 44,
   parameter int CHAN_HIGH = 43,
   parameter int RAW_W     = 12,
   parameter int EXP_LOW   = 1024,
   parameter int EXP_HIGH  = 3072,
   parameter int FRAC_W    = 14,
   parameter int GAIN_W    = 15,
   parameter int OFFS_W    = 16,
   parameter int OFFS_BIAS = 2,
   parameter bit ROUND     = 1'b0,
   localparam int SEL_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [SEL_W-1:0]  conv_sel_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [CHAN_W-1:0] req_chan_o,
   output logic [SEL_W-1:0]  req_conv_o,
   output logic              req_cal_o,
   input  logic              rsp_valid_i,
   input  logic [RAW_W-1:0]  rsp_data_i,
   output logic              wr_valid_o,
   output logic              wr_kind_o,
   output logic [SEL_W-1:0]  wr_conv_o,
   output logic [OFFS_W-1:0] wr_data_o,
   output logic              done_o,
   output logic              err_o
);

   localparam longint NUMER = longint'(EXP_HIGH - EXP_LOW) * (longint'(1) << FRAC_W);
   localparam int DVD_W     = $clog2(NUMER + 1);
   localparam logic [DVD_W-1:0]  NUMER_V  = DVD_W'(NUMER);
   localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

   if (EXP_HIGH <= EXP_LOW) begin : g_bad_exp
      $error("cal_const_seq: EXP_HIGH must exceed EXP_LOW");
   end
   if (EXP_HIGH >= 2 ** RAW_W) begin : g_bad_range
      $error("cal_const_seq: EXP_HIGH outside the raw range");
   end
   if (GAIN_W <= FRAC_W || OFFS_W < GAIN_W) begin : g_bad_gain
      $error("cal_const_seq: GAIN_W/OFFS_W inconsistent with FRAC_W");
   end
   if (CHAN_LOW == CHAN_HIGH || CHAN_LOW >= 2 ** CHAN_W || CHAN_HIGH >= 2 ** CHAN_W) begin : g_bad_chan
      $error("cal_const_seq: reference channels invalid");
   end
   if (NUM_CONV < 1) begin : g_bad_conv
      $error("cal_const_seq: NUM_CONV must be at least 1");
   end

   cal_state_e state_q, state_d;

   logic [SEL_W-1:0]         conv_q;
   logic [RAW_W-1:0]         raw_lo_q;
   logic [RAW_W-1:0]         raw_hi_q;
   logic [GAIN_W-1:0]        gain_q;
   logic signed [OFFS_W-1:0] offs_q;
   logic                     err_q;

   logic                     div_start;
   logic                     div_done;
   logic [DVD_W-1:0]         div_quot;
   logic [GAIN_W-1:0]        gain_sat;
   logic signed [OFFS_W-1:0] offs_calc;
   logic                     order_ok;

   assign order_ok = rsp_data_i > raw_lo_q;

   always_comb begin
      state_d   = state_q;
      div_start = 1'b0;
      unique case (state_q)
         ST_IDLE:           if (start_i) state_d = ST_REQ_LOW;
         ST_REQ_LOW:        if (req_ready_i) state_d = ST_WAIT_LOW;
         ST_WAIT_LOW:       if (rsp_valid_i) state_d = ST_REQ_HIGH;
         ST_REQ_HIGH:       if (req_ready_i) state_d = ST_WAIT_HIGH;
         ST_WAIT_HIGH: begin
            if (rsp_valid_i) begin
               if (order_ok) begin
                  div_start = 1'b1;
                  state_d   = ST_DIVIDE;
               end else begin
                  state_d   = ST_DONE;
               end
            end
         end
         ST_DIVIDE:         if (div_done) state_d = ST_COMPUTE_OFFSET;
         ST_COMPUTE_OFFSET: state_d = ST_WRITE_GAIN;
         ST_WRITE_GAIN:     state_d = ST_WRITE_OFFSET;
         ST_WRITE_OFFSET:   state_d = ST_DONE;
         ST_DONE:           state_d = ST_IDLE;
         default:           state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         conv_q   <= '0;
         raw_lo_q <= '0;
         raw_hi_q <= '0;
         gain_q   <= '0;
         offs_q   <= '0;
         err_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            conv_q <= conv_sel_i;
            err_q  <= 1'b0;
         end
         if (state_q == ST_WAIT_LOW && rsp_valid_i) begin
            raw_lo_q <= rsp_data_i;
         end
         if (state_q == ST_WAIT_HIGH && rsp_valid_i) begin
            raw_hi_q <= rsp_data_i;
            if (!order_ok) err_q <= 1'b1;
         end
         if (state_q == ST_DIVIDE && div_done) begin
            gain_q <= gain_sat;
         end
         if (state_q == ST_COMPUTE_OFFSET) begin
            offs_q <= offs_calc;
         end
      end
   end

   cal_restoring_div #(
      .DVD_W (DVD_W),
      .DVS_W (RAW_W)
   ) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (div_start),
      .dividend_i (NUMER_V),
      .divisor_i  (rsp_data_i - raw_lo_q),
      .done_o     (div_done),
      .quot_o     (div_quot)
   );

   if (DVD_W > GAIN_W) begin : g_sat
      assign gain_sat = (div_quot > DVD_W'(GAIN_MAX)) ? GAIN_MAX : div_quot[GAIN_W-1:0];
   end else begin : g_fit
      assign gain_sat = GAIN_W'(div_quot);
   end

   cal_offset_calc #(
      .GAIN_W    (GAIN_W),
      .RAW_W     (RAW_W),
      .FRAC_W    (FRAC_W),
      .OFFS_W    (OFFS_W),
      .EXP_HIGH  (EXP_HIGH),
      .OFFS_BIAS (OFFS_BIAS),
      .ROUND     (ROUND)
   ) u_offs (
      .gain_i (gain_q),
      .raw_i  (raw_hi_q),
      .offs_o (offs_calc)
   );

   assign req_valid_o = (state_q == ST_REQ_LOW) || (state_q == ST_REQ_HIGH);
   assign req_chan_o  = (state_q == ST_REQ_HIGH) ? CHAN_W'(CHAN_HIGH) : CHAN_W'(CHAN_LOW);
   assign req_conv_o  = conv_q;
   assign req_cal_o   = 1'b0;
   assign wr_valid_o  = (state_q == ST_WRITE_GAIN) || (state_q == ST_WRITE_OFFSET);
   assign wr_kind_o   = (state_q == ST_WRITE_OFFSET) ? WR_KIND_OFFSET : WR_KIND_GAIN;
   assign wr_conv_o   = conv_q;
   assign wr_data_o   = (state_q == ST_WRITE_OFFSET) ? offs_q : OFFS_W'(gain_q);
   assign done_o      = (state_q == ST_DONE);
   assign err_o       = (state_q == ST_DONE) && err_q;

   // R2: a pending request keeps its channel until accepted
   a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_chan_o)));

   // R6: writes only follow strictly increasing raw points
   a_r6_write_needs_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_o |-> (raw_hi_q > raw_lo_q));

   // R7: the gain write is followed directly by the offset write
   a_r7_gain_then_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_o && wr_kind_o == WR_KIND_GAIN) |=> (wr_valid_o && wr_kind_o == WR_KIND_OFFSET));

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R9: the converter tag cannot change while a sequence runs
   a_r9_conv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> $stable(conv_q));

endmodule

// File: tb/cal_const_seq_tb.sv
module cal_const_seq_tb;

   localparam time CYC = 10ns;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start_i = 1'b0;
   logic [0:0]  conv_sel_i = '0;
   logic        req_valid_o;
   logic        req_ready_i = 1'b0;
   logic [5:0]  req_chan_o;
   logic [0:0]  req_conv_o;
   logic        req_cal_o;
   logic        rsp_valid_i = 1'b0;
   logic [11:0] rsp_data_i = '0;
   logic        wr_valid_o;
   logic        wr_kind_o;
   logic [0:0]  wr_conv_o;
   logic [15:0] wr_data_o;
   logic        done_o;
   logic        err_o;

   int n_chk = 0;
   int n_err = 0;

   always #(CYC/2) clk_i = ~clk_i;

   cal_const_seq u_dut (
      .clk_i, .rst_ni, .start_i, .conv_sel_i,
      .req_valid_o, .req_ready_i, .req_chan_o, .req_conv_o, .req_cal_o,
      .rsp_valid_i, .rsp_data_i,
      .wr_valid_o, .wr_kind_o, .wr_conv_o, .wr_data_o,
      .done_o, .err_o
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint exp_gain(input int lo, input int hi);
      longint q;
      q = (longint'(2048) << 14) / (hi - lo);
      if (q > 32767) q = 32767;
      return q;
   endfunction

   function automatic longint exp_offs(input longint g, input int hi);
      return 3070 - ((g * hi) >> 14);
   endfunction

   // serve one conversion request; optionally pulse start while the response is pending
   task automatic serve_req(input int chan, input int conv, input int rdy_dly, input int rsp_dly,
                            input int data, input bit poke, input string req);
      bit seen = 0;
      for (int i = 0; i < 50; i++) begin
         if (req_valid_o) begin seen = 1; break; end
         @(negedge clk_i);
      end
      chk(req, "request raised", seen, 1);
      chk(req, "request channel", req_chan_o, chan);
      chk(req, "request cal bit", req_cal_o, 0);
      chk(req, "request converter", req_conv_o, conv);
      for (int i = 0; i < rdy_dly; i++) begin
         @(negedge clk_i);
         chk("R2", "request held", req_valid_o, 1);
         chk("R2", "channel held", req_chan_o, chan);
      end
      req_ready_i = 1'b1;
      @(negedge clk_i);
      req_ready_i = 1'b0;
      chk(req, "request dropped after accept", req_valid_o, 0);
      if (poke) begin
         start_i = 1'b1;
         conv_sel_i = 1'(conv ^ 1);
         @(negedge clk_i);
         start_i = 1'b0;
      end
      for (int i = 0; i < rsp_dly; i++) @(negedge clk_i);
      rsp_valid_i = 1'b1;
      rsp_data_i  = 12'(data);
      @(negedge clk_i);
      rsp_valid_i = 1'b0;
   endtask

   task automatic run_cal(input int conv, input int lo, input int hi, input int rdy_dly,
                          input int rsp_dly, input bit poke);
      bit     exp_e;
      int     wr_n = 0, g_idx = -1, o_idx = -1, d_idx = -1, cyc = 0;
      longint g_val = 0, o_val = 0, eg, eo;
      int     g_conv = -1, o_conv = -1;
      bit     err_at_done = 0;
      exp_e = (hi <= lo);
      eg = exp_e ? 0 : exp_gain(lo, hi);
      eo = exp_offs(eg, hi);

      @(negedge clk_i);
      start_i = 1'b1;
      conv_sel_i = 1'(conv);
      @(negedge clk_i);
      start_i = 1'b0;
      conv_sel_i = 1'(conv ^ 1);

      serve_req(44, conv, rdy_dly, rsp_dly, lo, poke, "R2");
      serve_req(43, conv, rdy_dly, rsp_dly, hi, 1'b0, "R3");

      for (int i = 0; i < 200; i++) begin
         if (err_o && !done_o) chk("R8", "err without done", 1, 0);
         if (wr_valid_o) begin
            wr_n++;
            if (wr_kind_o == 1'b0) begin
               g_idx = cyc; g_val = wr_data_o; g_conv = wr_conv_o;
            end else begin
               o_idx = cyc; o_val = longint'($signed(wr_data_o)); o_conv = wr_conv_o;
            end
         end
         if (done_o) begin d_idx = cyc; err_at_done = err_o; break; end
         cyc++;
         @(negedge clk_i);
      end
      chk("R8", "done seen", d_idx >= 0, 1);
      if (exp_e) begin
         chk("R6", "writes on abort", wr_n, 0);
         chk("R6", "err with done", err_at_done, 1);
      end else begin
         chk("R7", "write count", wr_n, 2);
         chk("R7", "offset follows gain", o_idx, g_idx + 1);
         chk("R7", "done follows offset", d_idx, o_idx + 1);
         chk("R7", "err low on success", err_at_done, 0);
         chk("R4", "gain value", g_val, eg);
         chk("R5", "offset value", o_val, eo);
         chk("R9", "gain write converter", g_conv, conv);
         chk("R9", "offset write converter", o_conv, conv);
      end
      @(negedge clk_i);
      chk("R8", "done one cycle", done_o, 0);
      if (poke) begin
         bit extra = 0;
         for (int i = 0; i < 10; i++) begin
            if (req_valid_o || wr_valid_o || done_o) extra = 1;
            @(negedge clk_i);
         end
         chk("R9", "no sequence from ignored start", extra, 0);
      end
   endtask

   task automatic test_reset();
      bit act = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk_i);
         if (req_valid_o || wr_valid_o || done_o || err_o) act = 1;
      end
      chk("R1", "outputs quiet after reset", act, 0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(CYC * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      test_reset();
      run_cal(0, 1024, 3072, 0, 0, 1'b0);   // ideal points, unity gain
      run_cal(1, 1010, 3105, 3, 2, 1'b0);   // handshake delays
      run_cal(0, 2000, 2500, 1, 0, 1'b0);   // R4 saturation
      run_cal(1, 1000, 2024, 0, 1, 1'b0);   // R4 span 1024 saturates
      run_cal(0, 1000, 2025, 0, 0, 1'b0);   // R4 span 1025 just fits
      run_cal(1, 2000, 2000, 0, 0, 1'b0);   // R6 equal points
      run_cal(0, 3000, 1000, 2, 0, 1'b0);   // R6 reversed points
      run_cal(0, 1100, 3000, 1, 3, 1'b1);   // R9 start while busy
      run_cal(1, 0, 4095, 0, 0, 1'b0);      // full range
      finish_run();
   end

endmodule